// File: doc/BRIEF.md
# Byte Deserializer with One-Shot Byte Ordering

This block sits behind a receive word aligner. It takes one byte per valid cycle at the full byte rate and packs each pair of accepted bytes into a 16-bit word, so words leave at half the byte rate. The byte accepted first goes to the low lane and the second to the high lane. Without further help, the pairing may straddle the framing boundary: the upper byte of one transmitted word ends up beside the lower byte of the next.

To repair this, the block watches the aligner's sync-status level. On the cycle that level goes from low to high, it looks at the low byte of the most recently emitted word. If that byte equals the second framing byte of a SONET-style A1A2 pattern, the lanes already line up and the block reports ordering complete. If it does not, one pad byte is put into the next accepted byte slot. Every later input byte is then carried one slot late through a single holding register. Nothing is lost, and the pairing flips to the correct phase.

The ordering decision is made once per reset. The done flag stays latched, and later sync edges are ignored until the synchronous digital reset is pulsed.

Top module: `bdes_order_top`

## Requirements
- R1: The first accepted byte of a pair lands in word_out[7:0] and the second in word_out[15:8]. The word appears on the clock edge that accepts the second byte.
- R2: word_vld is a one-cycle pulse, raised once for every two accepted byte slots. Cycles with in_vld low accept nothing and produce no pulse.
- R3: Only a low-to-high change of sync_lvl starts the ordering check, and it compares the current word_out[7:0] with the A2 byte (default 8'h28). Before any such change, mismatching words insert no pad and order_done stays low.
- R4: If word_out[7:0] equals A2 at the sync edge, no pad is inserted and order_done is high on the next cycle.
- R5: If word_out[7:0] differs from A2 at the sync edge, the next accepted byte slot carries exactly one pad byte in place of the input byte. The pad defaults to the A1 byte (8'hF6). order_done rises on the edge that consumes that slot.
- R6: After a pad, no input byte is dropped. Every later byte comes out one slot late, in arrival order.
- R7: Once high, order_done stays high until rst is asserted.
- R8: Ordering runs once per reset. Sync edges after order_done is high insert no pad and leave the pairing unchanged. After a reset, the check can run again.
- R9: While rst is high, word_out is cleared to zero, word_vld and order_done are low, and the next accepted byte goes to the low lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock |
| rst | input | 1 | Synchronous active-high digital reset |
| in_byte | input | 8 | Byte from the word aligner |
| in_vld | input | 1 | in_byte is valid this cycle |
| sync_lvl | input | 1 | Aligner sync-status level |
| word_out | output | 16 | Packed word, first byte in the low lane |
| word_vld | output | 1 | One-cycle pulse when word_out is new |
| order_done | output | 1 | Byte ordering complete, latched until reset |

## Verification
A wrong lane counter or a stale holding register shows up at the ports as soon as the next word_vld pulse. That pulse comes at most two accepted bytes later, as a swapped, repeated or missing byte in word_out. A wrong ordering decision shows one cycle after the sync edge in order_done, or one slot later as a missing or extra pad value in the low lane. A sticky flag that fails to hold, or a second pad, is visible after any later sync edge as a dropped order_done or a shifted pairing in the words that follow.

// File: rtl/bdes_pkg.sv
package bdes_pkg;
  typedef enum logic [1:0] {
    ORD_WAIT = 2'd0,
    ORD_PAD  = 2'd1,
    ORD_LOCK = 2'd2
  } ord_state_e;
endpackage

// File: rtl/bdes_edge.sv
module bdes_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/bdes_order_ctl.sv
module bdes_order_ctl
  import bdes_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [7:0]  A2_VAL = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] low_byte,
  output logic              pad_now,
  output logic              shift_mode,
  output logic              done
);
  ord_state_e st;
  logic       a2_hit;

  assign a2_hit  = (low_byte == BYTE_W'(A2_VAL));
  assign pad_now = (st == ORD_PAD) && in_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ORD_WAIT;
      shift_mode <= 1'b0;
      done       <= 1'b0;
    end else begin
      unique case (st)
        ORD_WAIT: begin
          if (rise) begin
            if (a2_hit) begin
              st   <= ORD_LOCK;
              done <= 1'b1;
            end else begin
              st <= ORD_PAD;
            end
          end
        end
        ORD_PAD: begin
          if (in_vld) begin
            st         <= ORD_LOCK;
            shift_mode <= 1'b1;
            done       <= 1'b1;
          end
        end
        ORD_LOCK: st <= ORD_LOCK;
        default:  st <= ORD_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/bdes_byte_src.sv
module bdes_byte_src #(
  parameter int         BYTE_W  = 8,
  parameter logic [7:0] PAD_VAL = 8'hF6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              pad_now,
  input  logic              shift_mode,
  input  logic              in_vld,
  output logic [BYTE_W-1:0] src_byte
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                                   hold_q <= '0;
    else if (in_vld && (pad_now || shift_mode)) hold_q <= in_byte;
  end

  always_comb begin
    if (pad_now)         src_byte = BYTE_W'(PAD_VAL);
    else if (shift_mode) src_byte = hold_q;
    else                 src_byte = in_byte;
  end
endmodule

// File: rtl/bdes_packer.sv
module bdes_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BYTE_W-1:0]         src_byte,
  input  logic                      src_vld,
  output logic [LANES*BYTE_W-1:0]   word_q,
  output logic                      word_vld_q
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LAST   = LANES - 1;

  logic [LANE_W-1:0] lane_q;
  logic [BYTE_W-1:0] stage [LAST];
  logic [LAST*BYTE_W-1:0] stage_flat;
  logic last_slot;

  assign last_slot = (lane_q == LANE_W'(LAST));

  for (genvar g = 0; g < LAST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)                                     stage[g] <= '0;
      else if (src_vld && lane_q == LANE_W'(g))    stage[g] <= src_byte;
    end
    assign stage_flat[g*BYTE_W +: BYTE_W] = stage[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= '0;
      word_q     <= '0;
      word_vld_q <= 1'b0;
    end else begin
      word_vld_q <= 1'b0;
      if (src_vld) begin
        if (last_slot) begin
          lane_q     <= '0;
          word_q     <= {src_byte, stage_flat};
          word_vld_q <= 1'b1;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bdes_order_top.sv
module bdes_order_top #(
  parameter int         BYTE_W  = 8,
  parameter logic [7:0] A1_VAL  = 8'hF6,
  parameter logic [7:0] A2_VAL  = 8'h28,
  parameter logic [7:0] PAD_VAL = A1_VAL
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                in_vld,
  input  logic                sync_lvl,
  output logic [2*BYTE_W-1:0] word_out,
  output logic                word_vld,
  output logic                order_done
);
  localparam int LANES = 2;

  logic              rise;
  logic              pad_now;
  logic              shift_mode;
  logic [BYTE_W-1:0] src_byte;

  bdes_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sync_lvl),
    .rise (rise)
  );

  bdes_order_ctl #(.BYTE_W(BYTE_W), .A2_VAL(A2_VAL)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .in_vld     (in_vld),
    .low_byte   (word_out[BYTE_W-1:0]),
    .pad_now    (pad_now),
    .shift_mode (shift_mode),
    .done       (order_done)
  );

  bdes_byte_src #(.BYTE_W(BYTE_W), .PAD_VAL(PAD_VAL)) u_src (
    .clk        (clk),
    .rst        (rst),
    .in_byte    (in_byte),
    .pad_now    (pad_now),
    .shift_mode (shift_mode),
    .in_vld     (in_vld),
    .src_byte   (src_byte)
  );

  bdes_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .src_byte   (src_byte),
    .src_vld    (in_vld),
    .word_q     (word_out),
    .word_vld_q (word_vld)
  );
endmodule

// File: rtl/bdes_chk.sv
module bdes_chk (
  input logic clk,
  input logic rst,
  input logic in_vld,
  input logic sync_lvl,
  input logic word_vld,
  input logic order_done
);
  // R2
  word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R2
  word_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(in_vld));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    order_done |=> order_done);

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(order_done) |-> ($past(in_vld) || $past(sync_lvl)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!order_done && !word_vld));
endmodule

bind bdes_order_top bdes_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_vld     (in_vld),
  .sync_lvl   (sync_lvl),
  .word_vld   (word_vld),
  .order_done (order_done)
);

// File: tb/sim_bdes_order_top.sv
`timescale 1ns/1ps
module sim_bdes_order_top;
  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_vld = 1'b0;
  logic        sync_lvl = 1'b0;
  logic [15:0] word_out;
  logic        word_vld;
  logic        order_done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bdes_order_top u0 (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_vld(in_vld),
    .sync_lvl(sync_lvl), .word_out(word_out), .word_vld(word_vld),
    .order_done(order_done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_vld = 1'b0; sync_lvl = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_byte = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 word_out", word_out, 16'h0000);
    check("R9 word_vld", 16'(word_vld), 16'h0);
    check("R9 order_done", 16'(order_done), 16'h0);
    rst = 1'b0;
  endtask

  task automatic t_pack();
    do_reset();
    push(8'h11);
    check("R2 no word after first byte", 16'(word_vld), 16'h0);
    push(8'h22);
    check("R2 word pulse", 16'(word_vld), 16'h1);
    check("R1 lane order", word_out, 16'h2211);
    idle();
    check("R2 pulse one cycle", 16'(word_vld), 16'h0);
    push(8'h33); idle(); idle();
    check("R2 gap ignored", 16'(word_vld), 16'h0);
    push(8'h44);
    check("R1 word with gap", word_out, 16'h4433);
    push(8'h28); push(8'h00);
    check("R3 no check without sync edge", 16'(order_done), 16'h0);
  endtask

  task automatic t_aligned();
    do_reset();
    push(A2); push(A1);
    check("R1 framing word", word_out, {A1, A2});
    sync_lvl = 1'b1; idle();
    check("R4 done on match", 16'(order_done), 16'h1);
    push(8'h01); push(8'h02);
    check("R4 no pad on match", word_out, 16'h0201);
    sync_lvl = 1'b0;
  endtask

  task automatic t_misaligned();
    do_reset();
    push(A1); push(A2);
    check("R3 mismatched word", word_out, {A2, A1});
    sync_lvl = 1'b1; idle();
    check("R5 done waits for pad", 16'(order_done), 16'h0);
    push(8'h01);
    check("R5 pad slot no word", 16'(word_vld), 16'h0);
    check("R5 done after pad", 16'(order_done), 16'h1);
    push(8'h02);
    check("R5 pad in low lane", word_out, {8'h01, A1});
    push(8'h03);
    push(8'h04);
    check("R6 bytes kept in order", word_out, 16'h0302);
  endtask

  task automatic t_once();
    sync_lvl = 1'b0; idle();
    sync_lvl = 1'b1; idle();
    check("R7 done held", 16'(order_done), 16'h1);
    push(8'h05);
    push(8'h06);
    check("R8 no second pad", word_out, 16'h0504);
    sync_lvl = 1'b0;
    do_reset();
    check("R7 reset clears done", 16'(order_done), 16'h0);
    push(A1); push(A2);
    sync_lvl = 1'b1; idle();
    push(8'h07);
    check("R8 ordering reruns after reset", 16'(order_done), 16'h1);
    push(8'h08);
    check("R8 pad after reset", word_out, {8'h07, A1});
    sync_lvl = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pack();
    t_aligned();
    t_misaligned();
    t_once();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule